// File: doc/BRIEF.md
# UART Transmitter with Automatic RS-485 Direction Control

This block is the send half of a UART. The host pushes bytes into a transmit queue through a single-cycle write strobe. A shift stage takes each byte from the queue and sends it as an asynchronous character. The shift stage advances only on an external oversampling baud enable, so the bit rate is set outside the block.

The RTS output can be driven by the transmitter itself, so it works as a driver-enable for a half-duplex RS-485 transceiver. It turns active as soon as the host writes. It stays active while anything is queued or being shifted, and it drops only once the final stop bit has left the line. The active level can be inverted. When automatic direction is off, RTS passes through either a flow-control value or a manually set bit.

A transmit-disable input freezes character starts. The queue keeps filling while it is set, and a character already in flight completes.

Top module: `uart_rs485_tx`

## Requirements
- R1: Each character on `txd` is one start bit at 0, then the eight data bits least significant first, then one stop bit at 1. Every bit lasts `OVERSAMPLE` asserted `baud_tick` cycles, and `txd` rests at 1 when no character is in flight.
- R2: The queue holds `FIFO_DEPTH` bytes and sends them in write order. A write made while it is full is discarded, and `wr_overflow` is 1 for exactly the one clock cycle after that write.
- R3: With `auto_dir_en` = 1, `rts` shows the active level in the clock cycle right after a cycle with `wr_en` = 1.
- R4: With `auto_dir_en` = 1, `rts` holds the active level while the queue is non-empty or a character is being shifted, including the gap between back-to-back characters. It returns to the inactive level within two clock cycles after the last baud tick of the final stop bit.
- R5: With `rts_invert` = 0, the active level is 0 and the inactive level is 1. With `rts_invert` = 1, the active level is 1 and the inactive level is 0.
- R6: With `auto_dir_en` = 0, `rts` equals `flow_rts` when `flow_ctrl_en` = 1 and equals `manual_rts` otherwise. With `auto_dir_en` = 1, neither `flow_rts` nor `manual_rts` has any effect on `rts`.
- R7: While `tx_disable` = 1, no new character starts, so `txd` stays at 1. Host writes are still stored until the queue is full.
- R8: A character that has already started when `tx_disable` rises is sent to the end of its stop bit.
- R9: After `tx_disable` falls with data queued, the next character's start bit begins on the first following `baud_tick`.
- R10: While `rst` is held, and right after it is released, `txd` = 1, `wr_overflow` = 0 and the queue is empty. With `auto_dir_en` = 1, `rts` is at the inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to queue |
| baud_tick | input | 1 | Oversampling baud enable |
| auto_dir_en | input | 1 | Transmitter drives RTS |
| rts_invert | input | 1 | Swap RTS active and inactive levels |
| tx_disable | input | 1 | Stop starting new characters |
| manual_rts | input | 1 | RTS level used when flow control is off |
| flow_ctrl_en | input | 1 | Select flow-control RTS value |
| flow_rts | input | 1 | RTS level from flow-control logic |
| txd | output | 1 | Serial output |
| rts | output | 1 | Request-to-send / driver enable |
| wr_overflow | output | 1 | One-cycle pulse after a discarded write |

## Verification
The bench builds the block with `FIFO_DEPTH` = 4 and `OVERSAMPLE` = 4, and holds `baud_tick` high. Each character then takes 40 clocks, and the queue fills after four writes. This keeps overflow, the full queue under disable, and back-to-back draining of a full queue within a few hundred cycles. At these sizes the RTS release edge and the start edge after disable clears can be sampled in exact clock cycles.

// File: rtl/uart_rs485_pkg.sv
package uart_rs485_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic auto_dir;
        logic invert;
        logic flow_en;
        logic flow_val;
        logic manual;
    } rts_ctrl_t;

    function automatic logic rts_level(input logic active, input logic invert);
        return active ? invert : ~invert;
    endfunction

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              overflow
);
    import uart_rs485_pkg::*;

    localparam int ADDR_W = cnt_width(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0]  count;
    logic              push, pull;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign push  = wr_en && !full;
    assign pull  = rd_en && !empty;
    assign rd_data = mem[rptr];

    function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
        return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            overflow <= wr_en && full;
            if (push) wptr <= bump(wptr);
            if (pull) rptr <= bump(rptr);
            case ({push, pull})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2
    push_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full && !rd_en) |=> !empty);

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en) |=> ($stable(count) && $stable(wptr)));

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              tx_disable,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              pop,
    output logic              busy,
    output logic              txd
);
    import uart_rs485_pkg::*;

    localparam int TICK_W = cnt_width(OVERSAMPLE);
    localparam int IDX_W  = cnt_width(DATA_W);

    tx_state_e         state;
    logic [TICK_W-1:0] tick_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              bit_end;

    assign bit_end = baud_tick && (tick_cnt == TICK_W'(OVERSAMPLE - 1));
    assign pop     = baud_tick && (state == TX_IDLE) && !fifo_empty && !tx_disable;
    assign busy    = (state != TX_IDLE);

    always_comb begin
        case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_IDLE;
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
        end else if (baud_tick) begin
            tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
            case (state)
                TX_IDLE: begin
                    tick_cnt <= '0;
                    if (pop) begin
                        shreg <= fifo_data;
                        state <= TX_START;
                    end
                end
                TX_START: if (bit_end) begin
                    bit_idx <= '0;
                    state   <= TX_DATA;
                end
                TX_DATA: if (bit_end) begin
                    shreg <= shreg >> 1;
                    if (bit_idx == IDX_W'(DATA_W - 1)) state <= TX_STOP;
                    else bit_idx <= bit_idx + 1'b1;
                end
                TX_STOP: if (bit_end) state <= TX_IDLE;
                default: state <= TX_IDLE;
            endcase
        end
    end

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE && tx_disable) |=> (state == TX_IDLE));

    // R8
    finish_char_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TX_DATA && tx_disable) |=> (state != TX_IDLE));

endmodule

// File: rtl/rts_arbiter.sv
module rts_arbiter (
    input  logic                      clk,
    input  logic                      rst,
    input  uart_rs485_pkg::rts_ctrl_t ctrl,
    input  logic                      wr_en,
    input  logic                      fifo_empty,
    input  logic                      shifter_busy,
    output logic                      rts
);
    import uart_rs485_pkg::*;

    logic dir_active_q;

    always_ff @(posedge clk) begin
        if (rst) dir_active_q <= 1'b0;
        else     dir_active_q <= wr_en || !fifo_empty || shifter_busy;
    end

    always_comb begin
        if (ctrl.auto_dir)     rts = rts_level(dir_active_q, ctrl.invert);
        else if (ctrl.flow_en) rts = ctrl.flow_val;
        else                   rts = ctrl.manual;
    end

endmodule

// File: rtl/uart_rs485_tx.sv
module uart_rs485_tx #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 64,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    input  logic              auto_dir_en,
    input  logic              rts_invert,
    input  logic              tx_disable,
    input  logic              manual_rts,
    input  logic              flow_ctrl_en,
    input  logic              flow_rts,
    output logic              txd,
    output logic              rts,
    output logic              wr_overflow
);
    import uart_rs485_pkg::*;

    logic [DATA_W-1:0] head_data;
    logic              fifo_empty, fifo_full, pop, busy;
    rts_ctrl_t         ctrl;

    assign ctrl = '{auto_dir: auto_dir_en, invert: rts_invert, flow_en: flow_ctrl_en,
                    flow_val: flow_rts, manual: manual_rts};

    tx_byte_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(pop), .rd_data(head_data), .empty(fifo_empty),
        .full(fifo_full), .overflow(wr_overflow)
    );

    tx_shifter #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_disable(tx_disable),
        .fifo_empty(fifo_empty), .fifo_data(head_data), .pop(pop),
        .busy(busy), .txd(txd)
    );

    rts_arbiter u_rts (
        .clk(clk), .rst(rst), .ctrl(ctrl), .wr_en(wr_en),
        .fifo_empty(fifo_empty), .shifter_busy(busy), .rts(rts)
    );

    // R3
    rts_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_dir_en && wr_en) |=> (!auto_dir_en || rts == rts_invert));

    // R4
    rts_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_dir_en && busy) |-> (rts == rts_invert));

    // R1
    line_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !fifo_full && fifo_empty) |-> txd);

endmodule

// File: tb/uart_rs485_tx_bench.sv
module uart_rs485_tx_bench;

    localparam int DEPTH = 4;
    localparam int OS    = 4;
    localparam logic [8:0] VEC [6] = '{
        {1'b0, 8'h55}, {1'b1, 8'hA3}, {1'b0, 8'h00},
        {1'b1, 8'hFF}, {1'b0, 8'h81}, {1'b1, 8'h3C}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic baud_tick = 1'b1;
    logic auto_dir_en = 1'b1, rts_invert = 1'b0, tx_disable = 1'b0;
    logic manual_rts = 1'b0, flow_ctrl_en = 1'b0, flow_rts = 1'b0;
    logic txd, rts, wr_overflow;

    int checks = 0, errors = 0, cycles = 0, watch_err = 0;
    logic watch_on = 1'b0, watch_lvl = 1'b0;

    always #2.5 clk = ~clk;

    uart_rs485_tx #(.DATA_W(8), .FIFO_DEPTH(DEPTH), .OVERSAMPLE(OS)) u_uart_rs485_tx (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .baud_tick(baud_tick),
        .auto_dir_en(auto_dir_en), .rts_invert(rts_invert), .tx_disable(tx_disable),
        .manual_rts(manual_rts), .flow_ctrl_en(flow_ctrl_en), .flow_rts(flow_rts),
        .txd(txd), .rts(rts), .wr_overflow(wr_overflow)
    );

    always @(negedge clk) begin
        if (watch_on && rts !== watch_lvl) watch_err++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Receive one character; checks framing (R1) and RTS at the stop bit (R4)
    task automatic recv(output logic [7:0] d, input logic act_lvl);
        while (txd !== 1'b0) @(negedge clk);
        repeat (OS / 2) @(negedge clk);
        check(txd == 1'b0, "R1 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
            repeat (OS) @(negedge clk);
            d[i] = txd;
        end
        repeat (OS) @(negedge clk);
        check(txd == 1'b1, "R1 stop bit", txd, 1);
        check(rts == act_lvl, "R4 rts held through stop bit", rts, act_lvl);
    endtask

    initial begin
        logic [7:0] got;
        int low_seen;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(txd == 1'b1 && wr_overflow == 1'b0 && rts == 1'b1, "R10 during reset",
              {txd, wr_overflow, rts}, 3'b101);
        rst = 1'b0;
        @(negedge clk);
        check(txd == 1'b1 && wr_overflow == 1'b0 && rts == 1'b1, "R10 after reset",
              {txd, wr_overflow, rts}, 3'b101);

        // Vector table: per-byte frame contents, polarity, RTS assert and release
        foreach (VEC[k]) begin
            rts_invert = VEC[k][8];
            @(negedge clk);
            check(rts == ~VEC[k][8], "R5 idle level", rts, ~VEC[k][8]);
            push(VEC[k][7:0]);
            check(rts == VEC[k][8], "R3 rts active after write", rts, VEC[k][8]);
            recv(got, VEC[k][8]);
            check(got == VEC[k][7:0], "R1 data bits", got, VEC[k][7:0]);
            repeat (3) @(negedge clk);
            check(rts == ~VEC[k][8], "R4 rts released after stop", rts, ~VEC[k][8]);
        end

        // R6 priority among RTS sources
        rts_invert = 1'b0;
        auto_dir_en = 1'b0; flow_ctrl_en = 1'b1; flow_rts = 1'b0; manual_rts = 1'b1;
        @(negedge clk);
        check(rts == 1'b0, "R6 flow value selected", rts, 0);
        flow_rts = 1'b1; manual_rts = 1'b0;
        @(negedge clk);
        check(rts == 1'b1, "R6 flow value selected", rts, 1);
        flow_ctrl_en = 1'b0;
        @(negedge clk);
        check(rts == 1'b0, "R6 manual bit selected", rts, 0);
        manual_rts = 1'b1;
        @(negedge clk);
        check(rts == 1'b1, "R6 manual bit selected", rts, 1);
        auto_dir_en = 1'b1; manual_rts = 1'b0; flow_ctrl_en = 1'b1; flow_rts = 1'b0;
        @(negedge clk);
        check(rts == 1'b1, "R6 auto overrides manual and flow", rts, 1);

        // R7 disable: queue fills, nothing starts; R2 overflow on fifth write
        tx_disable = 1'b1;
        push(8'h11); push(8'h22); push(8'h33); push(8'h44);
        check(wr_overflow == 1'b0, "R2 no overflow below full", wr_overflow, 0);
        push(8'h99);
        check(wr_overflow == 1'b1, "R2 overflow pulse", wr_overflow, 1);
        @(negedge clk);
        check(wr_overflow == 1'b0, "R2 overflow one cycle", wr_overflow, 0);
        low_seen = 0;
        for (int c = 0; c < 60; c++) begin
            if (txd !== 1'b1) low_seen++;
            @(negedge clk);
        end
        check(low_seen == 0, "R7 no start while disabled", low_seen, 0);
        check(rts == 1'b0, "R4 rts active with queued data", rts, 0);

        // R9 restart on next tick, then drain back-to-back with RTS held (R4)
        watch_lvl = 1'b0; watch_on = 1'b1;
        tx_disable = 1'b0;
        @(negedge clk);
        check(txd == 1'b0, "R9 start on next baud tick", txd, 0);
        recv(got, 1'b0); check(got == 8'h11, "R2 order byte 0", got, 8'h11);
        recv(got, 1'b0); check(got == 8'h22, "R2 order byte 1", got, 8'h22);
        recv(got, 1'b0); check(got == 8'h33, "R2 order byte 2", got, 8'h33);
        recv(got, 1'b0); check(got == 8'h44, "R2 order byte 3, overflow dropped", got, 8'h44);
        watch_on = 1'b0;
        check(watch_err == 0, "R4 rts steady across character gaps", watch_err, 0);
        repeat (3) @(negedge clk);
        check(rts == 1'b1 && txd == 1'b1, "R4 release after drain", {rts, txd}, 2'b11);

        // R8 disable raised mid-character: character completes, next waits
        push(8'hC5);
        fork
            recv(got, 1'b0);
            begin
                repeat (10) @(negedge clk);
                tx_disable = 1'b1;
                push(8'h5A);
            end
        join
        check(got == 8'hC5, "R8 in-flight character completes", got, 8'hC5);
        low_seen = 0;
        for (int c = 0; c < 50; c++) begin
            if (txd !== 1'b1) low_seen++;
            @(negedge clk);
        end
        check(low_seen == 0, "R7 queued byte held while disabled", low_seen, 0);
        tx_disable = 1'b0;
        @(negedge clk);
        check(txd == 1'b0, "R9 start after disable clears", txd, 0);
        recv(got, 1'b0);
        check(got == 8'h5A, "R9 released byte", got, 8'h5A);
        repeat (3) @(negedge clk);
        check(rts == 1'b1, "R4 final release", rts, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule